// File: doc/BRIEF.md
# Dual-Source Output Buffer Arbiter

This block merges two byte producers, a keyboard channel and an auxiliary (pointing device) channel, into the single read port of a host keyboard controller. Each channel has a one-byte holding register. A push loads the byte and marks the channel as holding data. Together the two "holding" levels form a two-bit pending mask: bit 0 is the keyboard, bit 1 is the auxiliary channel.

From that mask and an 8-bit mode register, the block derives several outputs:
- the output-buffer-full status flags and their copies on the output port,
- the read-source select,
- two registered interrupt levels.

The keyboard channel always wins. The auxiliary byte is visible, flagged and interrupting only while it is the sole pending source. A data read returns the selected byte and empties that channel in the same clock edge.

Top module: `obuf_arb`

## Requirements
- R1: After reset, both channels hold no data, every flag, select and interrupt output is 0, `rd_data` is 0x00, and the mode register is 0x03.
- R2: A push stores its byte in that channel at the next clock edge and marks the channel pending. Whenever any channel is pending, `stat_obf` and `outp_obf` are 1; otherwise both are 0.
- R3: `stat_aux_obf`, `outp_aux_obf` and `rd_sel_aux` are 1 exactly when the pending mask is 2'b10 (auxiliary pending, keyboard not pending).
- R4: `rd_data` shows the auxiliary byte when `rd_sel_aux` is 1. Otherwise it shows the keyboard byte, so the keyboard byte wins when both are pending.
- R5: A read (`rd_strobe` high for one cycle) empties only the selected channel. With both channels pending, the auxiliary channel stays pending and becomes the selected source.
- R6: A read and a push to the same channel in one cycle leave that channel pending, holding the newly pushed byte.
- R7: `irq_kbd` is 1 in the cycle after one in which the keyboard is pending, mode bit 0 is 1 and mode bit 4 is 0. It is 0 in the cycle after any other cycle.
- R8: `irq_aux` is 1 in the cycle after one in which the pending mask is 2'b10 and mode bit 1 is 1. It is 0 in the cycle after any other cycle. The two interrupts are never high together.
- R9: A mode write loads `mode_in` at the next clock edge. The interrupt levels follow the new mode one cycle later; the status flags do not depend on the mode at all.
- R10: A read while no channel is pending changes nothing: all flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_push | input | 1 | Load `kbd_byte` into the keyboard holding register |
| kbd_byte | input | 8 | Keyboard byte |
| aux_push | input | 1 | Load `aux_byte` into the auxiliary holding register |
| aux_byte | input | 8 | Auxiliary byte |
| mode_wr | input | 1 | Write `mode_in` into the mode register |
| mode_in | input | 8 | New mode value (bit 0 keyboard irq enable, bit 1 aux irq enable, bit 4 keyboard disable) |
| rd_strobe | input | 1 | Data-port read; empties the selected channel |
| rd_data | output | 8 | Byte of the selected channel |
| rd_sel_aux | output | 1 | 1 when the auxiliary channel is the read source |
| stat_obf | output | 1 | Status: some byte is pending |
| stat_aux_obf | output | 1 | Status: the pending byte is from the auxiliary channel |
| outp_obf | output | 1 | Output-port copy of `stat_obf` (port bit 4) |
| outp_aux_obf | output | 1 | Output-port copy of `stat_aux_obf` (port bit 5) |
| irq_kbd | output | 1 | Registered keyboard interrupt level |
| irq_aux | output | 1 | Registered auxiliary interrupt level |

## Verification
A holding bit left set or cleared in error shows at once, in the cycle after the push or read, on `stat_obf`, `stat_aux_obf` and the read mux. A wrong mask-to-priority mapping therefore appears as the wrong byte on `rd_data` before any interrupt moves. Interrupt faults, whether a lost gating bit or an inverted enable, show one cycle later on `irq_kbd` or `irq_aux`. The bench samples there after each push, read and mode write. Overlapping traffic, meaning both channels pending or a push and a read in the same cycle, exposes a pop of the wrong channel within one cycle.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;

    localparam int DATA_W   = 8;
    localparam int MODE_W   = 8;
    localparam int NUM_CH   = 2;

    // channel indices inside the pending mask
    localparam int CH_KBD   = 0;
    localparam int CH_AUX   = 1;

    // mode register bit positions
    localparam int MB_KBD_IE  = 0;
    localparam int MB_AUX_IE  = 1;
    localparam int MB_KBD_DIS = 4;

    localparam logic [NUM_CH-1:0] PEND_AUX_ONLY = 2'b10;

    typedef struct packed {
        logic              avail;
        logic [DATA_W-1:0] data;
    } chan_st_t;

    typedef struct packed {
        logic irq_kbd;
        logic irq_aux;
    } irq_st_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
    } top_st_t;

endpackage

// File: rtl/obuf_arb_chan.sv
module obuf_arb_chan
    import obuf_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              pop,
    output logic              avail,
    output logic [DATA_W-1:0] data
);

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.data  = byte_in;
            st_d.avail = 1'b1;
        end else if (pop) begin
            st_d.avail = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avail = st_q.avail;
    assign data  = st_q.data;

    AST_PUSH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (avail && data == $past(byte_in))); // R2
    AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> !avail); // R5
    AST_PUSH_WINS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push) |=> avail); // R6

endmodule

// File: rtl/obuf_arb_core.sv
module obuf_arb_core
    import obuf_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pend,
    input  logic [MODE_W-1:0] mode,
    output logic              any_pend,
    output logic              aux_only,
    output logic              irq_kbd,
    output logic              irq_aux
);

    irq_st_t irq_d, irq_q;
    logic    mode_unused;

    assign mode_unused = ^{mode[MODE_W-1:MB_KBD_DIS+1], mode[MB_KBD_DIS-1:MB_AUX_IE+1]};

    always_comb begin
        any_pend      = |pend;
        aux_only      = (pend == PEND_AUX_ONLY);
        irq_d.irq_kbd = pend[CH_KBD] && mode[MB_KBD_IE] && !mode[MB_KBD_DIS];
        irq_d.irq_aux = aux_only && mode[MB_AUX_IE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_kbd = irq_q.irq_kbd;
    assign irq_aux = irq_q.irq_aux;

    AST_AUX_NEEDS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        aux_only |-> any_pend); // R3
    AST_KIRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_kbd |-> $past(pend[CH_KBD] && mode[MB_KBD_IE] && !mode[MB_KBD_DIS])); // R7
    AST_AIRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_aux |-> $past(pend == PEND_AUX_ONLY && mode[MB_AUX_IE])); // R8
    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_kbd && irq_aux)); // R8

endmodule

// File: rtl/obuf_arb.sv
module obuf_arb
    import obuf_arb_pkg::*;
#(
    parameter logic [MODE_W-1:0] MODE_RST = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_push,
    input  logic [DATA_W-1:0] kbd_byte,
    input  logic              aux_push,
    input  logic [DATA_W-1:0] aux_byte,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sel_aux,
    output logic              stat_obf,
    output logic              stat_aux_obf,
    output logic              outp_obf,
    output logic              outp_aux_obf,
    output logic              irq_kbd,
    output logic              irq_aux
);

    top_st_t st_d, st_q;

    logic [NUM_CH-1:0] push_v, pop_v, avail_v;
    logic [DATA_W-1:0] byte_v [NUM_CH];
    logic [DATA_W-1:0] data_v [NUM_CH];
    logic              any_pend, aux_only;

    always_comb begin
        st_d = st_q;
        if (mode_wr) st_d.mode = mode_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.mode <= MODE_RST;
        else        st_q      <= st_d;
    end

    always_comb begin
        push_v[CH_KBD] = kbd_push;
        push_v[CH_AUX] = aux_push;
        byte_v[CH_KBD] = kbd_byte;
        byte_v[CH_AUX] = aux_byte;
        pop_v[CH_AUX]  = rd_strobe && aux_only;
        pop_v[CH_KBD]  = rd_strobe && !aux_only;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        obuf_arb_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (push_v[g]),
            .byte_in (byte_v[g]),
            .pop     (pop_v[g]),
            .avail   (avail_v[g]),
            .data    (data_v[g])
        );
    end

    obuf_arb_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (avail_v),
        .mode     (st_q.mode),
        .any_pend (any_pend),
        .aux_only (aux_only),
        .irq_kbd  (irq_kbd),
        .irq_aux  (irq_aux)
    );

    assign rd_sel_aux   = aux_only;
    assign rd_data      = aux_only ? data_v[CH_AUX] : data_v[CH_KBD];
    assign stat_obf     = any_pend;
    assign outp_obf     = any_pend;
    assign stat_aux_obf = aux_only;
    assign outp_aux_obf = aux_only;

    AST_KBD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && avail_v == 2'b11) |=> avail_v[CH_AUX]); // R5
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (st_q.mode == $past(mode_in))); // R9
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !any_pend && !kbd_push && !aux_push) |=> !stat_obf); // R10

endmodule

// File: tb/obuf_arb_test.sv
module obuf_arb_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kbd_push = 1'b0, aux_push = 1'b0, mode_wr = 1'b0, rd_strobe = 1'b0;
    logic [7:0] kbd_byte = '0, aux_byte = '0, mode_in = '0;
    logic [7:0] rd_data;
    logic       rd_sel_aux, stat_obf, stat_aux_obf, outp_obf, outp_aux_obf, irq_kbd, irq_aux;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    obuf_arb uut (
        .clk(clk), .rst_n(rst_n),
        .kbd_push(kbd_push), .kbd_byte(kbd_byte),
        .aux_push(aux_push), .aux_byte(aux_byte),
        .mode_wr(mode_wr), .mode_in(mode_in),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_sel_aux(rd_sel_aux),
        .stat_obf(stat_obf), .stat_aux_obf(stat_aux_obf),
        .outp_obf(outp_obf), .outp_aux_obf(outp_aux_obf),
        .irq_kbd(irq_kbd), .irq_aux(irq_aux)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // flags: {obf, aux_obf, outp_obf, outp_aux, sel_aux}
    task automatic chk_flags(input string req, input logic any, input logic aux);
        chk(req, {3'b0, stat_obf, stat_aux_obf, outp_obf, outp_aux_obf, rd_sel_aux},
                 {3'b0, any, aux, any, aux, aux});
    endtask

    task automatic chk_irq(input string req, input logic k, input logic a);
        chk(req, {6'b0, irq_kbd, irq_aux}, {6'b0, k, a});
    endtask

    task automatic push(input logic k, input logic [7:0] kb, input logic a, input logic [7:0] ab);
        kbd_push = k; kbd_byte = kb; aux_push = a; aux_byte = ab;
        step();
        kbd_push = 1'b0; aux_push = 1'b0;
    endtask

    task automatic rd();
        rd_strobe = 1'b1;
        step();
        rd_strobe = 1'b0;
    endtask

    task automatic wr_mode(input logic [7:0] m);
        mode_wr = 1'b1; mode_in = m;
        step();
        mode_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk_flags("R1 flags", 1'b0, 1'b0);
        chk_irq("R1 irq", 1'b0, 1'b0);
        chk("R1 rd_data", rd_data, 8'h00);
    endtask

    task automatic t_kbd_only();
        push(1'b1, 8'h5A, 1'b0, 8'h00);
        chk_flags("R2 kbd flags", 1'b1, 1'b0);
        chk("R4 kbd byte", rd_data, 8'h5A);
        step();
        chk_irq("R7 kbd irq", 1'b1, 1'b0);
        rd();
        chk_flags("R5 kbd read empties", 1'b0, 1'b0);
        step();
        chk_irq("R7 kbd irq drops", 1'b0, 1'b0);
    endtask

    task automatic t_aux_only();
        push(1'b0, 8'h00, 1'b1, 8'h3C);
        chk_flags("R3 aux flags", 1'b1, 1'b1);
        chk("R4 aux byte", rd_data, 8'h3C);
        step();
        chk_irq("R8 aux irq", 1'b0, 1'b1);
        rd();
        chk_flags("R5 aux read empties", 1'b0, 1'b0);
        step();
        chk_irq("R8 aux irq drops", 1'b0, 1'b0);
    endtask

    task automatic t_both();
        push(1'b0, 8'h00, 1'b1, 8'h11);
        push(1'b1, 8'h22, 1'b0, 8'h00);
        chk_flags("R3 both pending", 1'b1, 1'b0);
        chk("R4 kbd priority", rd_data, 8'h22);
        step();
        chk_irq("R8 both irq", 1'b1, 1'b0);
        rd();
        chk_flags("R5 aux kept", 1'b1, 1'b1);
        chk("R5 aux byte after", rd_data, 8'h11);
        step();
        chk_irq("R8 aux after kbd", 1'b0, 1'b1);
        rd();
        chk_flags("R5 both emptied", 1'b0, 1'b0);
        step();
    endtask

    task automatic t_push_read();
        push(1'b1, 8'h40, 1'b0, 8'h00);
        rd_strobe = 1'b1;
        push(1'b1, 8'h41, 1'b0, 8'h00);
        rd_strobe = 1'b0;
        chk_flags("R6 stays pending", 1'b1, 1'b0);
        chk("R6 new byte", rd_data, 8'h41);
        rd();
        chk_flags("R6 then empties", 1'b0, 1'b0);
        step();
    endtask

    task automatic t_mode();
        push(1'b1, 8'h77, 1'b0, 8'h00);
        step();
        chk_irq("R7 irq on", 1'b1, 1'b0);
        wr_mode(8'h13);
        step();
        chk_irq("R9 disable bit gates", 1'b0, 1'b0);
        chk_flags("R9 flags unaffected", 1'b1, 1'b0);
        wr_mode(8'h03);
        step();
        chk_irq("R9 re-enabled", 1'b1, 1'b0);
        wr_mode(8'h02);
        step();
        chk_irq("R7 enable bit clear", 1'b0, 1'b0);
        rd();
        wr_mode(8'h01);
        push(1'b0, 8'h00, 1'b1, 8'h99);
        step();
        chk_irq("R8 aux enable clear", 1'b0, 1'b0);
        chk_flags("R8 aux flag still set", 1'b1, 1'b1);
        wr_mode(8'h03);
        step();
        chk_irq("R9 aux re-enabled", 1'b0, 1'b1);
        rd();
        step();
    endtask

    task automatic t_empty_read();
        rd();
        chk_flags("R10 empty read", 1'b0, 1'b0);
        step();
        chk_irq("R10 empty irq", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_kbd_only();
        t_aux_only();
        t_both();
        t_push_read();
        t_mode();
        t_empty_read();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule